// File: doc/BRIEF.md
# Audio Bit and Frame Clock Divider

This block turns a stream of master-clock ticks into the two clocks an audio serial port needs: a bit clock and a left/right frame clock. Everything runs on one system clock. Each master-clock period reaches the block as a one-cycle tick strobe, and the block advances only on those ticks. The bit clock is the master clock divided by 2 or by 4. The frame clock is the bit clock divided by 32, 64 or 128.

A single enable runs both clocks or stops both. When the enable is low, both clocks are held low and both dividers return to zero. The master tick source has its own enable and is not handled here. Ratio settings are captured while the block is disabled. While it runs, new settings are taken only at a frame boundary, so a frame never ends up with a mixed length. Besides the two clock levels, the block gives one-cycle strobes that mark each rising and each falling bit-clock edge. A serial shifter can use these strobes without detecting the edges itself. The ports are plain control and status pins: the tick input is a strobe with no back-pressure, and it is never stalled.

Top module: `aud_clk_div`

## Requirements
- R1: While reset is asserted and in the first cycle after it, bclk, lrclk, bclk_rise and bclk_fall are all 0.
- R2: While enabled, bclk toggles on every master tick when the active bit selection is 0 (divide by 2). It toggles on every second master tick when the active bit selection is 1 (divide by 4).
- R3: The frame selection code sets the frame length in bit-clock periods: 2'b00 gives 32, 2'b01 gives 64 and 2'b10 gives 128. lrclk is low for the first half of each frame and high for the second half.
- R4: lrclk changes level only in the cycle where bclk goes from 1 to 0.
- R5: Frame code 2'b11 is reserved. When it is presented at a capture point, the frame length already in effect is kept.
- R6: Settings are captured every cycle while the enable is low. While enabled, they are captured only when lrclk returns from high to low, and the new values govern the next frame.
- R7: When the enable is sampled low, bclk and lrclk are 0 from the following cycle on, and master ticks have no effect until the block is enabled again.
- R8: After enabling, the first bit-clock edge is a rising edge. It comes on tick 1 for divide-by-2 and on tick 2 for divide-by-4.
- R9: bclk_rise is 1 for exactly the cycles in which bclk has just gone from 0 to 1. bclk_fall is 1 for exactly the cycles in which bclk has just gone from 1 to 0.
- R10: In a cycle that follows a cycle with no master tick, bclk keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclk_tick | input | 1 | One-cycle strobe, one per master-clock period |
| en | input | 1 | Runs both bit and frame clocks; low holds them low |
| bclk_div4 | input | 1 | Bit ratio select: 0 divide by 2, 1 divide by 4 |
| frame_sel | input | 2 | Frame ratio code: 00 = 32, 01 = 64, 10 = 128, 11 reserved |
| bclk | output | 1 | Bit clock level |
| lrclk | output | 1 | Frame clock level, low for the left half |
| bclk_rise | output | 1 | Strobe in the cycle bclk has just risen |
| bclk_fall | output | 1 | Strobe in the cycle bclk has just fallen |

## Verification
The bench sweeps every legal pair of bit and frame ratios, once with a tick on every cycle and once with ticks missing in a fixed pseudo-random pattern. Each cycle it compares all four outputs against a count of consumed ticks.

- A divider that counts system cycles instead of ticks drifts as soon as ticks are missing.
- An off-by-one half-frame count moves the lrclk transitions.
- A frame divider driven by rising bit-clock edges flips lrclk half a bit period early.

Directed runs change the ratios just after enabling. A design that applies settings at once, instead of at the frame boundary, places the first lrclk fall somewhere other than tick 64. Capturing the reserved code 11 in a design that does not hold the old ratio would select 128, so its frame transitions fall at the wrong tick counts. Ticks sent while disabled would show up as early edges after the next enable.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

  typedef enum logic [1:0] {
    FR_32  = 2'b00,
    FR_64  = 2'b01,
    FR_128 = 2'b10,
    FR_RSV = 2'b11
  } frame_code_e;

  typedef struct packed {
    logic        bit_div4;
    frame_code_e frame;
  } div_cfg_t;

  // Merge a requested setting into the current one; reserved frame code keeps the old ratio.
  function automatic div_cfg_t cfg_merge(input div_cfg_t cur, input logic req_div4,
                                         input logic [1:0] req_frame);
    div_cfg_t nxt;
    nxt.bit_div4 = req_div4;
    nxt.frame    = (frame_code_e'(req_frame) == FR_RSV) ? cur.frame : frame_code_e'(req_frame);
    return nxt;
  endfunction

endpackage

// File: rtl/aud_cfg_hold.sv
module aud_cfg_hold
  import aud_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       req_div4,
  input  logic [1:0] req_frame,
  output div_cfg_t   cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.bit_div4 <= 1'b0;
      cfg.frame    <= FR_32;
    end else if (load) begin
      cfg <= cfg_merge(cfg, req_div4, req_frame);
    end
  end

endmodule

// File: rtl/aud_bclk_stage.sv
module aud_bclk_stage #(
  parameter int unsigned CNT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mtick,
  input  logic [CNT_W-1:0] half_last,
  output logic             bclk,
  output logic             rise,
  output logic             fall,
  output logic             fall_now
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap     = en && mtick && (cnt == half_last);
  assign fall_now = wrap && bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      bclk <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= wrap && !bclk;
      fall <= fall_now;
      if (mtick) cnt <= wrap ? '0 : cnt + CNT_W'(1);
      if (wrap) bclk <= ~bclk;
    end
  end

endmodule

// File: rtl/aud_lr_stage.sv
module aud_lr_stage #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             bfall,
  input  logic [CNT_W-1:0] half_last,
  output logic             lrclk,
  output logic             boundary
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap     = en && bfall && (cnt == half_last);
  assign boundary = wrap && lrclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      lrclk <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      lrclk <= 1'b0;
    end else if (bfall) begin
      cnt <= wrap ? '0 : cnt + CNT_W'(1);
      if (wrap) lrclk <= ~lrclk;
    end
  end

endmodule

// File: rtl/aud_clk_div.sv
module aud_clk_div
  import aud_clk_pkg::*;
#(
  parameter int unsigned BIT_HALF_LO     = 1,
  parameter int unsigned BIT_HALF_HI     = 2,
  parameter int unsigned FRAME_BASE_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_tick,
  input  logic       en,
  input  logic       bclk_div4,
  input  logic [1:0] frame_sel,
  output logic       bclk,
  output logic       lrclk,
  output logic       bclk_rise,
  output logic       bclk_fall
);

  localparam int unsigned MCNT_W  = (BIT_HALF_HI > 1) ? $clog2(BIT_HALF_HI) : 1;
  localparam int unsigned FCNT_W  = FRAME_BASE_LOG2 + 1;
  localparam int unsigned FHALF_0 = 2 ** (FRAME_BASE_LOG2 - 1);

  div_cfg_t          cfg;
  logic              frame_edge;
  logic              bfall_now;
  logic [MCNT_W-1:0] bit_last;
  logic [FCNT_W-1:0] frame_last;

  aud_cfg_hold u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (!en || frame_edge),
    .req_div4 (bclk_div4),
    .req_frame(frame_sel),
    .cfg      (cfg)
  );

  assign bit_last = cfg.bit_div4 ? MCNT_W'(BIT_HALF_HI - 1) : MCNT_W'(BIT_HALF_LO - 1);

  always_comb begin
    unique case (cfg.frame)
      FR_64:   frame_last = FCNT_W'(FHALF_0 * 2 - 1);
      FR_128:  frame_last = FCNT_W'(FHALF_0 * 4 - 1);
      default: frame_last = FCNT_W'(FHALF_0 - 1);
    endcase
  end

  aud_bclk_stage #(.CNT_W(MCNT_W)) u_bit (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .mtick    (mclk_tick),
    .half_last(bit_last),
    .bclk     (bclk),
    .rise     (bclk_rise),
    .fall     (bclk_fall),
    .fall_now (bfall_now)
  );

  aud_lr_stage #(.CNT_W(FCNT_W)) u_lr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .bfall    (bfall_now),
    .half_last(frame_last),
    .lrclk    (lrclk),
    .boundary (frame_edge)
  );

endmodule

// File: rtl/aud_clk_div_chk.sv
module aud_clk_div_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic mclk_tick,
  input logic bclk,
  input logic lrclk,
  input logic bclk_rise,
  input logic bclk_fall
);

  // R4
  lr_on_bfall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(lrclk)) |-> $fell(bclk));

  // R7
  off_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk && !lrclk));

  // R9
  rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |-> $rose(bclk));

  // R9
  rise_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> bclk_rise);

  // R9
  fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall |-> $fell(bclk));

  // R10
  no_tick_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(mclk_tick)) |-> $stable(bclk));

endmodule

bind aud_clk_div aud_clk_div_chk u_chk (.*);

// File: tb/sim_aud_clk_div.sv
module sim_aud_clk_div;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mclk_tick;
  logic       en;
  logic       bclk_div4;
  logic [1:0] frame_sel;
  logic       bclk, lrclk, bclk_rise, bclk_fall;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  int  m_n = 0;
  int  m_tgp = 0;
  bit  m_used = 0;
  bit  m_on = 0;
  int  m_b = 0;
  int  m_f = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  aud_clk_div u0 (
    .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .en(en),
    .bclk_div4(bclk_div4), .frame_sel(frame_sel),
    .bclk(bclk), .lrclk(lrclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int tg_of(input int n, input int b);
    return n / (b != 0 ? 2 : 1);
  endfunction

  // Compare outputs to the arithmetic model built from the tick count
  task automatic model_check();
    int tg, ex_b, ex_lr, fh;
    bit edge_now;
    tg = tg_of(m_n, m_b);
    fh = 16 << m_f;
    ex_b = tg & 1;
    ex_lr = ((tg / 2) / fh) & 1;
    edge_now = m_used && (tg != m_tgp);
    chk(bclk == ex_b[0], "R2/R8 bclk", int'(bclk), ex_b);
    chk(lrclk == ex_lr[0], "R3/R4 lrclk", int'(lrclk), ex_lr);
    chk(bclk_rise == (edge_now && ex_b == 1), "R9 rise", int'(bclk_rise), int'(edge_now && ex_b == 1));
    chk(bclk_fall == (edge_now && ex_b == 0), "R9 fall", int'(bclk_fall), int'(edge_now && ex_b == 0));
  endtask

  // One cycle: check outputs, drive inputs, advance model, wait for next negedge
  task automatic cyc(input logic e, input logic t);
    if (m_on) model_check();
    en = e;
    mclk_tick = t;
    if (!e) begin
      m_n = 0; m_tgp = 0; m_used = 0;
    end else if (t) begin
      m_tgp = tg_of(m_n, m_b); m_n++; m_used = 1;
    end else begin
      m_used = 0;
    end
    @(negedge clk);
  endtask

  function automatic logic next_tick(input int pat);
    if (pat == 0) return 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0] | lfsr[3];
  endfunction

  // Directed run: record tick counts at lrclk transitions
  task automatic trace(input int ncyc, output int tr0, output int tr1, output int tr2);
    int idx;
    int k;
    logic prev;
    idx = 0; k = 0; prev = lrclk;
    tr0 = -1; tr1 = -1; tr2 = -1;
    for (int i = 0; i < ncyc; i++) begin
      en = 1'b1; mclk_tick = 1'b1;
      @(negedge clk);
      k++;
      if (lrclk != prev) begin
        chk(bclk_fall == 1'b1, "R4 lr with fall", int'(bclk_fall), 1);
        if (idx == 0) tr0 = k; else if (idx == 1) tr1 = k; else if (idx == 2) tr2 = k;
        idx++;
      end
      prev = lrclk;
    end
  endtask

  initial begin
    int a0, a1, a2;
    rst_n = 1'b0; en = 1'b0; mclk_tick = 1'b0; bclk_div4 = 1'b0; frame_sel = 2'b00;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk({bclk, lrclk, bclk_rise, bclk_fall} == 4'b0, "R1 reset", int'({bclk, lrclk, bclk_rise, bclk_fall}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bclk, lrclk, bclk_rise, bclk_fall} == 4'b0, "R1 after reset", int'({bclk, lrclk, bclk_rise, bclk_fall}), 0);

    // Sweep: all legal ratios, dense and gapped ticks
    for (int b = 0; b < 2; b++) begin
      for (int f = 0; f < 3; f++) begin
        for (int pat = 0; pat < 2; pat++) begin
          int goal;
          m_on = 0;
          bclk_div4 = b[0]; frame_sel = f[1:0];
          // R7: ticks while disabled do nothing
          for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1);
          chk({bclk, lrclk} == 2'b00, "R7 off", int'({bclk, lrclk}), 0);
          m_b = b; m_f = f; m_on = 1;
          goal = 2 * (32 << f) * (b != 0 ? 4 : 2) + 5;
          while (m_n < goal) cyc(1'b1, next_tick(pat));
          cyc(1'b0, 1'b1);
          cyc(1'b0, 1'b1);
          m_on = 0;
        end
      end
    end

    // R6: mid-run change applies only at the frame boundary
    bclk_div4 = 1'b0; frame_sel = 2'b00;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0);
    bclk_div4 = 1'b1; frame_sel = 2'b01;
    trace(260, a0, a1, a2);
    chk(a0 == 32, "R6 first lr rise", a0, 32);
    chk(a1 == 64, "R6 boundary", a1, 64);
    chk(a2 == 192, "R6 new ratio used", a2, 192);

    // R5: reserved code captured while disabled keeps 64
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    frame_sel = 2'b11;
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    chk({bclk, lrclk} == 2'b00, "R7 disabled again", int'({bclk, lrclk}), 0);
    trace(270, a0, a1, a2);
    chk(a0 == 128, "R5 half frame", a0, 128);
    chk(a1 == 256, "R5 full frame", a1, 256);

    // R5: reserved code at a running boundary also keeps the ratio
    cyc(1'b0, 1'b0);
    bclk_div4 = 1'b0; frame_sel = 2'b00;
    cyc(1'b0, 1'b0);
    frame_sel = 2'b11;
    trace(140, a0, a1, a2);
    chk(a0 == 32 && a1 == 64 && a2 == 96, "R5 running reserved", a2, 96);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run incomplete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule